// File: doc/BRIEF.md
# Ready-Request Stall Controller

This block sits beside a core that advances one step per enabled clock. It turns a level-sensitive ready request into a stall of that core. When a request arrives, the controller does not stop the core at once. It waits until the core issues its first bus read, because reads can be stalled safely. If no read comes, it forces the stall after a fixed number of steps, so that a run of writes cannot delay the stall forever.

The stall ends as soon as the request is withdrawn. The core uses `run_o` as its gate for the step action. `halt_o` shows the stalled state. Arbitration of the bus and the core itself are outside this block.

The default countdown length is three steps. A step counts toward it only when `step_i` is high. The step that carries the triggering read, or the last step of the countdown, still executes. The stall takes effect from the next clock.

Top module: `rdy_halt_ctrl`

## Requirements
- R1: After reset is released, `halt_o` is 0 and `run_o` follows `step_i`, whatever the level of `rdy_i`.
- R2: `run_o` is 1 exactly when `step_i` is 1 and `halt_o` is 0. The step that triggers a stall therefore still runs.
- R3: A clock with `rdy_i`=1, `step_i`=1 and `read_i`=1, while `halt_o` is 0, sets `halt_o` to 1 from the next clock. This holds also in the clock where `rdy_i` first rises.
- R4: If `rdy_i` rises while `halt_o` is 0 and stays high with no read step, `halt_o` becomes 1 after the third step taken with `rdy_i`=1. The step in the rising clock counts as the first (COUNT_INIT=3).
- R5: Clocks with `step_i`=0 never set `halt_o` and do not advance the countdown.
- R6: While `halt_o` is 1, a clock with `rdy_i`=0 clears `halt_o` from the next clock.
- R7: Dropping `rdy_i` before the stall abandons the countdown. The next rise of `rdy_i` starts a full countdown again.
- R8: With `rdy_i`=0, no combination of `step_i` and `read_i` sets `halt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_i | input | 1 | Ready request level; 1 asks for a stall |
| step_i | input | 1 | Core wants to execute a step this clock |
| read_i | input | 1 | The step this clock is a bus read |
| halt_o | output | 1 | Core is stalled |
| run_o | output | 1 | Core may execute its step this clock |

## Verification
The assertions assume that `read_i` is meaningful only when `step_i` is high. They also assume that all inputs are synchronous to `clk_i` and stable around the rising edge. The bench changes inputs only just after the falling edge and drives them from its own tasks. The random stimulus holds `rdy_i` at each level for several clocks, so that both the read-triggered stall and the full countdown occur. Directed cases cover a read in the same clock as the rise, idle clocks inside the countdown, and an abandoned countdown.

// File: rtl/rdy_halt_pkg.sv
package rdy_halt_pkg;
  function automatic int cnt_width(input int init);
    return (init < 2) ? 1 : $clog2(init + 1);
  endfunction
endpackage

// File: rtl/rdy_halt_edge.sv
module rdy_halt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic rise_o
);
  logic rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= rdy_i;
  end

  assign rise_o = rdy_i & ~rdy_q;
endmodule

// File: rtl/rdy_halt_count.sv
module rdy_halt_count #(
  parameter int COUNT_INIT = 3,
  parameter int CNT_W      = rdy_halt_pkg::cnt_width(COUNT_INIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic rise_i,
  input  logic halt_i,
  input  logic step_i,
  input  logic read_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(COUNT_INIT);
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, left;
  logic             active, tick;

  assign active = rdy_i & ~halt_i;
  assign left   = rise_i ? INIT_V : cnt_q;
  // a read step stalls on its own; only non-read steps consume the budget
  assign tick   = active & step_i & ~read_i;

  always_comb begin
    cnt_d = left;
    if (!active)             cnt_d = '0;
    else if (tick && left != '0) cnt_d = left - ONE_V;
  end

  assign expire_o = tick & (left == ONE_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rdy_halt_state.sv
module rdy_halt_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic step_i,
  input  logic read_i,
  input  logic expire_i,
  output logic halt_o
);
  logic halt_q, halt_d;

  always_comb begin
    if (halt_q) halt_d = rdy_i;
    else        halt_d = rdy_i & step_i & (read_i | expire_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else         halt_q <= halt_d;
  end

  assign halt_o = halt_q;
endmodule

// File: rtl/rdy_halt_ctrl.sv
module rdy_halt_ctrl #(
  parameter int COUNT_INIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic step_i,
  input  logic read_i,
  output logic halt_o,
  output logic run_o
);
  localparam int CNT_W = rdy_halt_pkg::cnt_width(COUNT_INIT);

  logic rise, expire, halt;

  rdy_halt_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rdy_i (rdy_i),
    .rise_o(rise)
  );

  rdy_halt_count #(.COUNT_INIT(COUNT_INIT), .CNT_W(CNT_W)) i_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rdy_i   (rdy_i),
    .rise_i  (rise),
    .halt_i  (halt),
    .step_i  (step_i),
    .read_i  (read_i),
    .expire_o(expire)
  );

  rdy_halt_state i_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rdy_i   (rdy_i),
    .step_i  (step_i),
    .read_i  (read_i),
    .expire_i(expire),
    .halt_o  (halt)
  );

  assign halt_o = halt;
  assign run_o  = step_i & ~halt;
endmodule

// File: rtl/rdy_halt_chk.sv
module rdy_halt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rdy_i,
  input logic step_i,
  input logic read_i,
  input logic halt_o,
  input logic run_o
);
  // R3
  read_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && rdy_i && step_i && read_i) |=> halt_o);
  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !rdy_i) |=> !halt_o);
  // R5
  idle_no_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !step_i) |=> !halt_o);
  // R8
  no_req_no_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !rdy_i) |=> !halt_o);
  // R2
  halted_no_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && $past(halt_o) && rdy_i) |-> !run_o);
endmodule

bind rdy_halt_ctrl rdy_halt_chk i_rdy_halt_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .rdy_i (rdy_i),
  .step_i(step_i),
  .read_i(read_i),
  .halt_o(halt_o),
  .run_o (run_o)
);

// File: tb/test_rdy_halt_ctrl.sv
module test_rdy_halt_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rdy_i = 1'b0, step_i = 1'b0, read_i = 1'b0;
  logic halt_o, run_o;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  // reference state
  bit m_halt = 1'b0, m_prev = 1'b0;
  int m_left = 0;

  always #2 clk_i = ~clk_i;

  rdy_halt_ctrl i_rdy_halt_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_i(rdy_i), .step_i(step_i),
    .read_i(read_i), .halt_o(halt_o), .run_o(run_o)
  );

  function automatic void check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function automatic void model_step(bit r, bit s, bit rd);
    if (m_halt) begin
      if (!r) begin m_halt = 1'b0; m_left = 0; end
    end else if (!r) begin
      m_left = 0;
    end else begin
      if (!m_prev) m_left = 3;
      if (s) begin
        if (rd) m_halt = 1'b1;
        else begin
          m_left--;
          if (m_left == 0) m_halt = 1'b1;
        end
      end
    end
    m_prev = r;
  endfunction

  task automatic cyc(string req, bit r, bit s, bit rd);
    @(negedge clk_i);
    rdy_i = r; step_i = s; read_i = rd;
    #1;
    check(req, "halt_o", halt_o, m_halt);
    check("R2", "run_o", run_o, s & ~m_halt);
    @(posedge clk_i);
    model_step(r, s, rd);
  endtask

  initial begin
    #20000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1541));
    #9 rst_ni = 1'b1;
    // R1 reset state, request held high without steps
    cyc("R1", 1, 0, 0);
    cyc("R1", 1, 1, 0);
    cyc("R1", 0, 1, 1);
    // R8 reads with no request
    cyc("R8", 0, 1, 1);
    cyc("R8", 0, 1, 0);
    cyc("R8", 0, 1, 1);
    // R3 read in the rising clock
    cyc("R3", 1, 1, 1);
    cyc("R3", 1, 1, 0);
    cyc("R6", 0, 0, 0);
    cyc("R6", 0, 1, 0);
    // R4 full countdown of non-read steps
    cyc("R4", 1, 1, 0);
    cyc("R4", 1, 1, 0);
    cyc("R4", 1, 1, 0);
    cyc("R4", 1, 1, 0);
    cyc("R4", 1, 1, 1);
    cyc("R6", 0, 1, 0);
    // R5 idle clocks inside the countdown
    cyc("R5", 1, 1, 0);
    cyc("R5", 1, 0, 1);
    cyc("R5", 1, 0, 0);
    cyc("R5", 1, 1, 0);
    cyc("R5", 1, 0, 0);
    cyc("R5", 1, 1, 0);
    cyc("R5", 1, 1, 0);
    cyc("R6", 0, 0, 0);
    // R7 abandoned countdown restarts in full
    cyc("R7", 1, 1, 0);
    cyc("R7", 1, 1, 0);
    cyc("R7", 0, 1, 0);
    cyc("R7", 1, 1, 0);
    cyc("R7", 1, 1, 0);
    cyc("R7", 1, 1, 0);
    cyc("R7", 1, 1, 0);
    cyc("R6", 0, 1, 0);
    // random mix, request level held for runs
    for (int i = 0; i < 4000; i++) begin
      bit r = ($urandom_range(0, 9) < 6);
      int run = $urandom_range(1, 8);
      for (int k = 0; k < run; k++) begin
        bit s  = ($urandom_range(0, 3) != 0);
        bit rd = s & ($urandom_range(0, 4) == 0);
        cyc("R4", r, s, rd);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule